// File: doc/BRIEF.md
# Received Pause Quanta Timer

This block sits after the receive-side frame decoder of an Ethernet MAC and acts on flow-control (pause) frames. For each decoded pause frame it gets a strobe, the 16-bit pause time in quanta and a flag saying whether the frame was addressed to a unicast or a multicast destination. If the control word enables that destination type, the block loads a countdown with the pause time. It then holds the local transmitter off until the countdown reaches zero.

One quantum is 512 bit times: 12.8 ns at 40 Gb/s and 5.12 ns at 100 Gb/s. The clock period usually does not divide that evenly. So each clock adds a programmable fraction of a quantum, in 1/256 steps, to an 8-bit accumulator, and every carry out of it removes one quantum from the count. The delta is round(256 x Tclk / Tquantum). For example, a 3.2 ns clock at 40 Gb/s gives 64, which is four clocks per quantum. A newly accepted frame always replaces the running countdown, and a pause time of zero resumes transmission at once.

Top module: `pause_quanta_timer`

## Requirements
- R1: After reset the control word is all zero (both destination enables off, delta 0), the remaining count `quanta_left` is 0 and `tx_hold` is low; a frame received before any control write is ignored.
- R2: A clock edge with `cfg_we` high stores `cfg_wdata` as the control word, and it is used from the next edge: bit 9 enables unicast frames, bit 8 enables multicast frames, and bits [7:0] are the per-clock delta in 1/256 quantum.
- R3: A frame strobe (`rx_pause_valid`) whose destination type is enabled (`rx_pause_mcast` 0 = unicast, 1 = multicast) loads `quanta_left` with `rx_pause_time` at that edge and clears the fractional accumulator.
- R4: A frame strobe whose destination type is disabled leaves `quanta_left` unchanged.
- R5: On each edge with a nonzero count and no load, the delta is added modulo 256 to the accumulator, and each carry decrements `quanta_left` by exactly one. A load of N quanta therefore reaches zero exactly ceil(N*256/delta) edges after the load edge.
- R6: An accepted frame that arrives during a running countdown replaces the count and restarts the fraction from zero.
- R7: An accepted frame with pause time 0 clears `quanta_left` and drops `tx_hold` at that edge.
- R8: `tx_hold` is high exactly when `quanta_left` is nonzero.
- R9: With delta 0 the countdown is frozen: `quanta_left` stays at its value and `tx_hold` stays high until a new frame arrives or a nonzero delta is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 10 | Control word: [9] unicast enable, [8] multicast enable, [7:0] delta |
| rx_pause_valid | input | 1 | One-cycle strobe for a decoded pause frame |
| rx_pause_mcast | input | 1 | Destination type of the frame: 0 unicast, 1 multicast |
| rx_pause_time | input | 16 | Pause time of the frame in quanta |
| tx_hold | output | 1 | Transmit hold request |
| quanta_left | output | 16 | Remaining pause quanta |

## Verification
An accepted frame shows up in `quanta_left` one edge after its strobe. A control write affects the countdown from the edge after the write edge. After a load of N quanta, `tx_hold` stays high for exactly ceil(N*256/delta) further edges. The bench drives all inputs on falling edges and samples on falling edges, so the first sample after a strobe shows the loaded value. It then counts the falling edges at which the hold is still high and compares that count with the ceiling formula. The count is computed in the bench for a sweep of deltas (including 64 and 128) and pause times, with separate runs for the enable matrix, override, zero pause time and frozen delta.

// File: rtl/pqt_pkg.sv
package pqt_pkg;
  localparam int unsigned PQT_QUANTA_W_DEF = 16;
  localparam int unsigned PQT_FRAC_W_DEF   = 8;

  typedef enum logic {
    DEST_UCAST = 1'b0,
    DEST_MCAST = 1'b1
  } pqt_dest_e;
endpackage

// File: rtl/pqt_ctrl_reg.sv
module pqt_ctrl_reg #(
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned CTRL_W = FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic              ucast_en,
  output logic              mcast_en,
  output logic [FRAC_W-1:0] delta
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (we) ctrl_q <= wdata;
  end

  assign ucast_en = ctrl_q[FRAC_W+1];
  assign mcast_en = ctrl_q[FRAC_W];
  assign delta    = ctrl_q[FRAC_W-1:0];
endmodule

// File: rtl/pqt_accept.sv
module pqt_accept
  import pqt_pkg::*;
(
  input  logic valid,
  input  logic mcast,
  input  logic ucast_en,
  input  logic mcast_en,
  output logic load
);
  pqt_dest_e dest;

  assign dest = pqt_dest_e'(mcast);

  always_comb begin
    unique case (dest)
      DEST_MCAST: load = valid & mcast_en;
      default:    load = valid & ucast_en;
    endcase
  end
endmodule

// File: rtl/pqt_countdown.sv
module pqt_countdown #(
  parameter int unsigned QUANTA_W = 16,
  parameter int unsigned FRAC_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [QUANTA_W-1:0] load_val,
  input  logic [FRAC_W-1:0]   delta,
  output logic [QUANTA_W-1:0] count,
  output logic                tick,
  output logic                active
);
  // Fraction plus delta, with the carry in the top bit.
  function automatic logic [FRAC_W:0] frac_step(input logic [FRAC_W-1:0] acc,
                                                input logic [FRAC_W-1:0] d);
    return {1'b0, acc} + {1'b0, d};
  endfunction

  logic [QUANTA_W-1:0] count_q;
  logic [FRAC_W-1:0]   acc_q;
  logic [FRAC_W:0]     step;

  assign step   = frac_step(acc_q, delta);
  assign active = (count_q != '0);
  assign tick   = active & step[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      acc_q   <= '0;
    end else if (load) begin
      count_q <= load_val;
      acc_q   <= '0;
    end else if (active) begin
      acc_q <= step[FRAC_W-1:0];
      if (tick) count_q <= count_q - 1'b1;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer
  import pqt_pkg::*;
#(
  parameter int unsigned QUANTA_W = PQT_QUANTA_W_DEF,
  parameter int unsigned FRAC_W   = PQT_FRAC_W_DEF,
  localparam int unsigned CTRL_W  = FRAC_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CTRL_W-1:0]   cfg_wdata,
  input  logic                rx_pause_valid,
  input  logic                rx_pause_mcast,
  input  logic [QUANTA_W-1:0] rx_pause_time,
  output logic                tx_hold,
  output logic [QUANTA_W-1:0] quanta_left
);
  logic              ucast_en;
  logic              mcast_en;
  logic [FRAC_W-1:0] cur_delta;
  logic              load_evt;
  logic              tick_evt;
  logic              active;

  pqt_ctrl_reg #(.FRAC_W(FRAC_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .ucast_en (ucast_en),
    .mcast_en (mcast_en),
    .delta    (cur_delta)
  );

  pqt_accept u_accept (
    .valid    (rx_pause_valid),
    .mcast    (rx_pause_mcast),
    .ucast_en (ucast_en),
    .mcast_en (mcast_en),
    .load     (load_evt)
  );

  pqt_countdown #(.QUANTA_W(QUANTA_W), .FRAC_W(FRAC_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .load_val (rx_pause_time),
    .delta    (cur_delta),
    .count    (quanta_left),
    .tick     (tick_evt),
    .active   (active)
  );

  assign tx_hold = active;
endmodule

// File: rtl/pqt_checker.sv
module pqt_checker #(
  parameter int unsigned QUANTA_W = 16,
  parameter int unsigned FRAC_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                load_evt,
  input logic                tick_evt,
  input logic [QUANTA_W-1:0] load_val,
  input logic [FRAC_W-1:0]   delta,
  input logic [QUANTA_W-1:0] quanta_left,
  input logic                tx_hold
);
  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> quanta_left == $past(load_val));

  // R5
  tick_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_evt && !load_evt) |=> quanta_left == $past(quanta_left) - 1'b1);

  // R5
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> quanta_left <= $past(quanta_left));

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && delta == '0) |=> $stable(quanta_left));

  // R8
  hold_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hold == (quanta_left != '0));
endmodule

bind pause_quanta_timer pqt_checker #(.QUANTA_W(QUANTA_W), .FRAC_W(FRAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_evt    (load_evt),
  .tick_evt    (tick_evt),
  .load_val    (rx_pause_time),
  .delta       (cur_delta),
  .quanta_left (quanta_left),
  .tx_hold     (tx_hold)
);

// File: tb/sim_pause_quanta_timer.sv
module sim_pause_quanta_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_wdata = '0;
  logic        rx_pause_valid = 1'b0;
  logic        rx_pause_mcast = 1'b0;
  logic [15:0] rx_pause_time = '0;
  logic        tx_hold;
  logic [15:0] quanta_left;

  int checks = 0;
  int fails  = 0;
  int hold_mismatch = 0;

  always #5 clk = ~clk;

  pause_quanta_timer u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .cfg_wdata      (cfg_wdata),
    .rx_pause_valid (rx_pause_valid),
    .rx_pause_mcast (rx_pause_mcast),
    .rx_pause_time  (rx_pause_time),
    .tx_hold        (tx_hold),
    .quanta_left    (quanta_left)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // control word: [9] unicast en, [8] multicast en, [7:0] delta
  task automatic write_cfg(input bit u, input bit m, input int d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {u, m, 8'(d)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input bit mc, input int t);
    @(negedge clk);
    rx_pause_valid = 1'b1;
    rx_pause_mcast = mc;
    rx_pause_time  = 16'(t);
    @(negedge clk);
    rx_pause_valid = 1'b0;
  endtask

  // counts falling edges with hold high, starting right after a load
  task automatic measure(output int n);
    n = 0;
    hold_mismatch = 0;
    while (tx_hold && n < 5000) begin
      if (tx_hold != (quanta_left != 0)) hold_mismatch++;
      n++;
      @(negedge clk);
    end
    if (tx_hold != (quanta_left != 0)) hold_mismatch++;
  endtask

  function automatic int expect_len(input int n, input int d);
    return (n * 256 + d - 1) / d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int deltas[6] = '{1, 3, 64, 100, 128, 255};
    int times[4]  = '{1, 2, 3, 7};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and ignored frame with reset control
    check_eq("R1 quanta_left", quanta_left, 0);
    check_eq("R1 tx_hold", tx_hold, 0);
    send(1'b0, 5);
    check_eq("R1 ucast ignored", quanta_left, 0);
    send(1'b1, 5);
    check_eq("R1 mcast ignored", quanta_left, 0);

    // R2 R3 R4 enable matrix with frozen delta
    for (int u = 0; u < 2; u++) begin
      for (int m = 0; m < 2; m++) begin
        for (int mc = 0; mc < 2; mc++) begin
          write_cfg(u[0], m[0], 0);
          send(mc[0], 4);
          check_eq(((mc ? m : u) != 0) ? "R3 enabled load" : "R4 disabled ignored",
                   quanta_left, ((mc ? m : u) != 0) ? 4 : 0);
          write_cfg(1'b1, 1'b1, 0);
          send(1'b0, 0);
        end
      end
    end

    // R4 disabled type leaves a frozen running count unchanged
    write_cfg(1'b1, 1'b0, 0);
    send(1'b0, 5);
    send(1'b1, 9);
    check_eq("R4 count kept", quanta_left, 5);
    write_cfg(1'b1, 1'b1, 0);
    send(1'b0, 0);

    // R5 R8 sweep of deltas and pause times (R2 delta field)
    foreach (deltas[i]) begin
      write_cfg(1'b1, 1'b1, deltas[i]);
      foreach (times[j]) begin
        send(j[0], times[j]);
        check_eq("R3 loaded value", quanta_left, times[j]);
        measure(n);
        check_eq($sformatf("R5 hold length d=%0d n=%0d", deltas[i], times[j]),
                 n, expect_len(times[j], deltas[i]));
        check_eq("R8 hold tracks count", hold_mismatch, 0);
      end
    end

    // R9 delta zero freezes, then R2 a new delta resumes
    write_cfg(1'b1, 1'b1, 0);
    send(1'b1, 6);
    repeat (50) @(negedge clk);
    check_eq("R9 frozen count", quanta_left, 6);
    check_eq("R9 hold held", tx_hold, 1);
    write_cfg(1'b1, 1'b1, 128);
    measure(n);
    check_eq("R2 resumed with delta 128", n, 12);

    // R7 zero pause time ends the pause at once
    write_cfg(1'b1, 1'b1, 64);
    send(1'b0, 9);
    repeat (5) @(negedge clk);
    send(1'b0, 0);
    check_eq("R7 count cleared", quanta_left, 0);
    check_eq("R7 hold dropped", tx_hold, 0);

    // R6 override restarts count and fraction
    write_cfg(1'b1, 1'b1, 100);
    send(1'b0, 5);
    @(negedge clk);
    send(1'b1, 1);
    check_eq("R6 override value", quanta_left, 1);
    measure(n);
    check_eq("R6 override length", n, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule